// File: doc/BRIEF.md
# Filtered Hardware/Software Reset Controller

This block produces the internal resets of a network controller core from two sources. The first is an active-low external reset pin. It passes through a synchronizer and then a pulse-width filter, so that short low glitches are thrown away. The second is a software reset bit held in the configuration register that the block keeps.

Two resets come out of the block:

- A full reset that clears every register.
- A core reset for the rest of the controller. It is raised by either source. It leaves the preserved registers alone: interface mode, address pointer, configuration and setup.

The preserved registers live inside this block. Software writes them through plain write strobes, and their contents come back out on ports. The transmit enable leaves the block only through a gate. That gate holds it off while any reset is active.

Top module: `rstfilt_ctrl`

## Requirements
- R1: The pin is active low. When it is held low for at least MIN_LOW consecutive clock edges (5 by default), full_rst_o rises. It rises at the edge SYNC_STAGES+MIN_LOW-1 edges after the first edge at which the pin is low. With the defaults that is 6 edges later.
- R2: A low pulse spanning fewer than MIN_LOW edges produces no full reset. The width count restarts whenever the synchronized pin is seen high. So two 4-edge pulses separated by a single high edge produce no full reset, and the registers keep their values.
- R3: full_rst_o stays high while the pin stays low. It falls at the edge SYNC_STAGES edges after the first edge at which the pin is high again.
- R4: A full reset sets the configuration, setup, address pointer and mode registers to zero. This includes configuration bit 7, so core_rst_o drops together with full_rst_o.
- R5: Writing the configuration register with bit 7 = 1 raises core_rst_o right after that edge, while full_rst_o stays low. core_rst_o stays high as long as bit 7 reads 1, and it drops right after the edge that writes bit 7 = 0.
- R6: A software reset leaves the mode, address pointer, setup and configuration registers unchanged. Writes to them are still stored while the software reset is active.
- R7: tx_en_o equals configuration bit 0 while no reset is active. It is 0 whenever core_rst_o or full_rst_o is high.
- R8: The register writes behave as follows around a full reset:
  - A write presented at the edge where full_rst_o rises is lost, and the registers read zero after it.
  - Writes made while full_rst_o is high are ignored.
  - A write presented at the edge where full_rst_o falls is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| pin_rst_n | input | 1 | Raw external reset pin, active low, asynchronous |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data (bit 7 software reset, bit 0 transmit enable) |
| setup_wr | input | 1 | Setup register write strobe |
| setup_wdata | input | 8 | Setup write data |
| aptr_wr | input | 1 | Address pointer write strobe |
| aptr_wdata | input | AP_W (11) | Address pointer write data |
| mode_wr | input | 1 | Interface mode write strobe |
| mode_wdata | input | MODE_W (2) | Interface mode write data |
| full_rst_o | output | 1 | Filtered hardware reset, clears all registers |
| core_rst_o | output | 1 | Reset for the non-preserved core logic, either source |
| tx_en_o | output | 1 | Gated transmitter enable |
| cfg_q_o | output | 8 | Configuration register contents |
| setup_q_o | output | 8 | Setup register contents |
| aptr_q_o | output | AP_W (11) | Address pointer contents |
| mode_q_o | output | MODE_W (2) | Interface mode contents |

## Verification
A register write and the rise of the filtered hardware reset can fall on the same clock edge. The bench provokes this by presenting a configuration write that sets bit 7, together with a setup write, at exactly the edge on which the width count completes. It judges the result by checking that both registers read zero and the transmit enable is off afterwards. The release edge is provoked the same way, with a write at the edge where full reset falls, and that write must be stored.

// File: rtl/rstfilt_pkg.sv
package rstfilt_pkg;
   localparam int unsigned REG_W     = 8;
   localparam int unsigned SWRST_BIT = 7;
   localparam int unsigned TXEN_BIT  = 0;

   function automatic int unsigned cnt_bits(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/rstfilt_sync.sv
module rstfilt_sync #(
   parameter int unsigned STAGES = 2,
   parameter bit          INIT   = 1'b0
) (
   input  logic clk_i,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rstfilt_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q = {STAGES{INIT}};

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i) chain_q[0] <= d_i;
      end else begin : g_next
         always_ff @(posedge clk_i) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rstfilt_width.sv
module rstfilt_width
   import rstfilt_pkg::*;
#(
   parameter int unsigned MIN_LOW = 5
) (
   input  logic clk_i,
   input  logic low_n_i,
   input  logic armed_i,
   output logic rst_next_o,
   output logic rst_q_o
);
   localparam int unsigned CNT_W = cnt_bits(MIN_LOW);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOW);
   localparam logic [CNT_W-1:0] CNT_ARM = CNT_W'(MIN_LOW - 1);

   if (MIN_LOW < 2) begin : g_bad_min
      $error("rstfilt_width: MIN_LOW must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             hw_q;
   logic             hw_d;

   always_comb begin
      if (low_n_i) begin
         cnt_d = '0;
      end else if (cnt_q == CNT_MAX) begin
         cnt_d = cnt_q;
      end else begin
         cnt_d = cnt_q + 1'b1;
      end
      hw_d = !low_n_i && (cnt_q >= CNT_ARM);
   end

   always_ff @(posedge clk_i) begin
      cnt_q <= cnt_d;
      hw_q  <= hw_d;
   end

   assign rst_next_o = hw_d;
   assign rst_q_o    = hw_q;

   assert_rise_at_limit_R1: assert property (@(posedge clk_i) disable iff (!armed_i)
      $rose(hw_q) |-> (cnt_q == CNT_MAX));

   assert_short_low_ignored_R2: assert property (@(posedge clk_i) disable iff (!armed_i)
      (!hw_q && low_n_i) |=> !hw_q);

   assert_release_on_high_R3: assert property (@(posedge clk_i) disable iff (!armed_i)
      low_n_i |=> !hw_q);
endmodule

// File: rtl/rstfilt_field.sv
module rstfilt_field #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         clr_i,
   input  logic         armed_i,
   input  logic         wr_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_width
      $error("rstfilt_field: W must be at least 1");
   end

   logic [W-1:0] val_q;

   always_ff @(posedge clk_i) begin
      if (clr_i) begin
         val_q <= '0;
      end else if (wr_i) begin
         val_q <= d_i;
      end
   end

   assign q_o = val_q;

   assert_clear_on_full_R4: assert property (@(posedge clk_i) disable iff (!armed_i)
      clr_i |=> (q_o == '0));

   assert_kept_without_write_R6: assert property (@(posedge clk_i) disable iff (!armed_i)
      (!clr_i && !wr_i) |=> $stable(q_o));

   assert_write_stored_R8: assert property (@(posedge clk_i) disable iff (!armed_i)
      (!clr_i && wr_i) |=> (q_o == $past(d_i)));
endmodule

// File: rtl/rstfilt_ctrl.sv
module rstfilt_ctrl
   import rstfilt_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MIN_LOW     = 5,
   parameter int unsigned AP_W        = 11,
   parameter int unsigned MODE_W      = 2,
   parameter bit          TX_REG      = 1'b0
) (
   input  logic              clk,
   input  logic              pin_rst_n,
   input  logic              cfg_wr,
   input  logic [REG_W-1:0]  cfg_wdata,
   input  logic              setup_wr,
   input  logic [REG_W-1:0]  setup_wdata,
   input  logic              aptr_wr,
   input  logic [AP_W-1:0]   aptr_wdata,
   input  logic              mode_wr,
   input  logic [MODE_W-1:0] mode_wdata,
   output logic              full_rst_o,
   output logic              core_rst_o,
   output logic              tx_en_o,
   output logic [REG_W-1:0]  cfg_q_o,
   output logic [REG_W-1:0]  setup_q_o,
   output logic [AP_W-1:0]   aptr_q_o,
   output logic [MODE_W-1:0] mode_q_o
);
   if (AP_W < 1 || AP_W > 16) begin : g_bad_ap
      $error("rstfilt_ctrl: AP_W must lie in 1..16");
   end
   if (MODE_W < 1) begin : g_bad_mode
      $error("rstfilt_ctrl: MODE_W must be at least 1");
   end
   if (SWRST_BIT == TXEN_BIT || SWRST_BIT >= REG_W) begin : g_bad_bits
      $error("rstfilt_ctrl: control bit positions are inconsistent");
   end

   logic pin_sync_n;
   logic hw_next;
   logic hw_q;
   logic armed_q = 1'b0;
   logic sw_bit;
   logic tx_raw;

   rstfilt_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync (
      .clk_i (clk),
      .d_i   (pin_rst_n),
      .q_o   (pin_sync_n)
   );

   rstfilt_width #(.MIN_LOW(MIN_LOW)) u_width (
      .clk_i      (clk),
      .low_n_i    (pin_sync_n),
      .armed_i    (armed_q),
      .rst_next_o (hw_next),
      .rst_q_o    (hw_q)
   );

   always_ff @(posedge clk) armed_q <= armed_q | hw_q;

   rstfilt_field #(.W(REG_W)) u_cfg (
      .clk_i (clk), .clr_i (hw_next), .armed_i (armed_q),
      .wr_i  (cfg_wr), .d_i (cfg_wdata), .q_o (cfg_q_o)
   );

   rstfilt_field #(.W(REG_W)) u_setup (
      .clk_i (clk), .clr_i (hw_next), .armed_i (armed_q),
      .wr_i  (setup_wr), .d_i (setup_wdata), .q_o (setup_q_o)
   );

   rstfilt_field #(.W(AP_W)) u_aptr (
      .clk_i (clk), .clr_i (hw_next), .armed_i (armed_q),
      .wr_i  (aptr_wr), .d_i (aptr_wdata), .q_o (aptr_q_o)
   );

   rstfilt_field #(.W(MODE_W)) u_mode (
      .clk_i (clk), .clr_i (hw_next), .armed_i (armed_q),
      .wr_i  (mode_wr), .d_i (mode_wdata), .q_o (mode_q_o)
   );

   assign sw_bit     = cfg_q_o[SWRST_BIT];
   assign full_rst_o = hw_q;
   assign core_rst_o = hw_q | sw_bit;
   assign tx_raw     = cfg_q_o[TXEN_BIT];

   if (TX_REG) begin : g_tx_reg
      logic tx_q;
      always_ff @(posedge clk) begin
         tx_q <= tx_raw && !hw_next && !(cfg_wr ? cfg_wdata[SWRST_BIT] : sw_bit);
      end
      assign tx_en_o = tx_q && !core_rst_o;
   end else begin : g_tx_comb
      assign tx_en_o = tx_raw && !core_rst_o;
   end

   assert_sw_write_starts_R5: assert property (@(posedge clk) disable iff (!armed_q)
      (cfg_wr && cfg_wdata[SWRST_BIT] && !hw_next) |=> (core_rst_o && !full_rst_o));

   assert_sw_write_ends_R5: assert property (@(posedge clk) disable iff (!armed_q)
      (cfg_wr && !cfg_wdata[SWRST_BIT] && !hw_next) |=> !core_rst_o);

   assert_tx_off_in_reset_R7: assert property (@(posedge clk) disable iff (!armed_q)
      (full_rst_o || core_rst_o) |-> !tx_en_o);

   assert_full_drops_sw_R4: assert property (@(posedge clk) disable iff (!armed_q)
      $fell(full_rst_o) |-> !core_rst_o);
endmodule

// File: tb/rstfilt_ctrl_bench.sv
`timescale 1ns/1ps
module rstfilt_ctrl_bench;
   logic        clk = 1'b0;
   logic        pin_rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic        setup_wr = 1'b0;
   logic [7:0]  setup_wdata = '0;
   logic        aptr_wr = 1'b0;
   logic [10:0] aptr_wdata = '0;
   logic        mode_wr = 1'b0;
   logic [1:0]  mode_wdata = '0;
   logic        full_rst_o, core_rst_o, tx_en_o;
   logic [7:0]  cfg_q_o, setup_q_o;
   logic [10:0] aptr_q_o;
   logic [1:0]  mode_q_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   rstfilt_ctrl u_rstfilt_ctrl (
      .clk(clk), .pin_rst_n(pin_rst_n),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .setup_wr(setup_wr), .setup_wdata(setup_wdata),
      .aptr_wr(aptr_wr), .aptr_wdata(aptr_wdata),
      .mode_wr(mode_wr), .mode_wdata(mode_wdata),
      .full_rst_o(full_rst_o), .core_rst_o(core_rst_o), .tx_en_o(tx_en_o),
      .cfg_q_o(cfg_q_o), .setup_q_o(setup_q_o),
      .aptr_q_o(aptr_q_o), .mode_q_o(mode_q_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load_all(input logic [7:0] c, input logic [7:0] s,
                           input logic [10:0] a, input logic [1:0] m);
      @(negedge clk);
      cfg_wr = 1'b1;   cfg_wdata = c;
      setup_wr = 1'b1; setup_wdata = s;
      aptr_wr = 1'b1;  aptr_wdata = a;
      mode_wr = 1'b1;  mode_wdata = m;
      step();
      cfg_wr = 1'b0; setup_wr = 1'b0; aptr_wr = 1'b0; mode_wr = 1'b0;
   endtask

   task automatic write_cfg(input logic [7:0] c);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_wdata = c;
      step();
      cfg_wr = 1'b0;
   endtask

   task automatic release_pin();
      @(negedge clk);
      pin_rst_n = 1'b1;
      repeat (3) step();
   endtask

   task automatic t_power_reset();
      repeat (10) step();
      check("R1 full reset while pin held low", full_rst_o, 1);
      check("R4 cfg cleared in full reset", cfg_q_o, 0);
      check("R7 tx off in full reset", tx_en_o, 0);
      pin_rst_n = 1'b1;
      step();
      check("R3 still high one edge after release", full_rst_o, 1);
      step();
      check("R3 still high two... edge 1", full_rst_o, 1);
      step();
      check("R3 falls at second edge after high", full_rst_o, 0);
      check("R4 core reset low after release", core_rst_o, 0);
      check("R4 aptr zero", aptr_q_o, 0);
      check("R4 setup zero", setup_q_o, 0);
      check("R4 mode zero", mode_q_o, 0);
   endtask

   task automatic t_glitch();
      logic seen;
      seen = 1'b0;
      load_all(8'h01, 8'h5A, 11'h2C3, 2'd2);
      pin_rst_n = 1'b0;
      for (int i = 0; i < 4; i++) begin
         step();
         seen |= full_rst_o;
      end
      pin_rst_n = 1'b1;
      step();
      seen |= full_rst_o;
      pin_rst_n = 1'b0;
      for (int i = 0; i < 4; i++) begin
         step();
         seen |= full_rst_o;
      end
      pin_rst_n = 1'b1;
      for (int i = 0; i < 6; i++) begin
         step();
         seen |= full_rst_o;
      end
      check("R2 short pulses give no full reset", seen, 0);
      check("R2 setup kept after glitch", setup_q_o, 8'h5A);
      check("R2 aptr kept after glitch", aptr_q_o, 11'h2C3);
      check("R2 mode kept after glitch", mode_q_o, 2'd2);
      check("R7 tx enabled with bit 0 set", tx_en_o, 1);
   endtask

   task automatic t_min_pulse();
      load_all(8'h01, 8'hA5, 11'h111, 2'd1);
      pin_rst_n = 1'b0;
      for (int i = 0; i < 8; i++) begin
         step();
         if (i == 4) pin_rst_n = 1'b1;
         check($sformatf("R1 five-edge pulse, edge %0d", i), full_rst_o, (i == 6) ? 1 : 0);
         if (i == 6) begin
            check("R4 setup cleared by minimum pulse", setup_q_o, 0);
            check("R4 cfg cleared by minimum pulse", cfg_q_o, 0);
         end
      end
   endtask

   task automatic t_software();
      load_all(8'h01, 8'h3C, 11'h0F0, 2'd3);
      check("R7 tx follows cfg bit 0", tx_en_o, 1);
      write_cfg(8'h81);
      check("R5 core reset after bit 7 write", core_rst_o, 1);
      check("R5 full reset stays low", full_rst_o, 0);
      check("R7 tx off in software reset", tx_en_o, 0);
      check("R6 cfg not altered", cfg_q_o, 8'h81);
      check("R6 setup not altered", setup_q_o, 8'h3C);
      check("R6 mode not altered", mode_q_o, 2'd3);
      repeat (3) step();
      check("R5 core reset held while bit 7 set", core_rst_o, 1);
      @(negedge clk);
      aptr_wr = 1'b1; aptr_wdata = 11'h155;
      step();
      aptr_wr = 1'b0;
      check("R6 aptr write accepted in software reset", aptr_q_o, 11'h155);
      write_cfg(8'h01);
      check("R5 core reset released by bit 7 clear", core_rst_o, 0);
      check("R7 tx back on after release", tx_en_o, 1);
   endtask

   task automatic t_hw_clears_sw();
      write_cfg(8'h80);
      check("R5 software reset active", core_rst_o, 1);
      pin_rst_n = 1'b0;
      repeat (9) step();
      release_pin();
      check("R4 hardware reset ends software reset", core_rst_o, 0);
      check("R4 cfg bit 7 cleared", cfg_q_o, 0);
   endtask

   task automatic t_collide();
      load_all(8'h01, 8'h33, 11'h044, 2'd1);
      pin_rst_n = 1'b0;
      for (int i = 0; i < 6; i++) step();
      cfg_wr = 1'b1; cfg_wdata = 8'h81;
      setup_wr = 1'b1; setup_wdata = 8'h77;
      step();
      cfg_wr = 1'b0; setup_wr = 1'b0;
      check("R8 full reset rises at the write edge", full_rst_o, 1);
      check("R8 cfg write at rise edge lost", cfg_q_o, 0);
      check("R8 setup write at rise edge lost", setup_q_o, 0);
      check("R7 tx off at collision", tx_en_o, 0);
      write_cfg(8'h42);
      check("R8 write ignored during full reset", cfg_q_o, 0);
      pin_rst_n = 1'b1;
      step();
      step();
      cfg_wr = 1'b1; cfg_wdata = 8'h05;
      step();
      cfg_wr = 1'b0;
      check("R8 full reset low at release edge", full_rst_o, 0);
      check("R8 write at release edge stored", cfg_q_o, 8'h05);
      check("R7 tx on after release write", tx_en_o, 1);
   endtask

   initial begin
      #(5.0 * 20000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_power_reset();
      t_glitch();
      t_min_pulse();
      release_pin();
      t_software();
      t_hw_clears_sw();
      t_collide();
      repeat (2) step();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule